// File: doc/BRIEF.md
# SPI Word FIFOs with Threshold Interrupts

This block sits between a register-side port and a serial shift engine. Software writes words for transmission and reads received words through one shared data address. An 8-word transmit FIFO feeds the engine, which pulls words with a take strobe. An 8-word receive FIFO collects the words the engine delivers.

Each FIFO has a flush control and a 4-bit threshold. A small interrupt unit holds sticky status flags, an enable register and a write-1-to-clear register. The clear register shares its address with the status register.

The receive-complete flag rises when the receive FIFO fill reaches the programmed receive threshold. The receive-overrun flag rises when a word arrives while the receive FIFO is full. A transmit-complete flag rises when the engine takes the last queued transmit word. A single interrupt line is the OR of the enabled flags.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each FIFO holds up to 8 words of 32 bits. The FIFOs preserve order. A write to the data address (reg_addr=0) while the transmit FIFO holds 8 words is dropped. tx_valid is high exactly when the transmit FIFO is non-empty, and tx_word presents its oldest word.
- R2: The FIFO control register is at reg_addr=1. It holds the transmit threshold in bits 11:8 and the receive threshold in bits 3:0, and both read back. Writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO. Bits 12 and 4 read as 0. A flush takes priority over a push or pop in the same cycle.
- R3: Bit 0 of the status register (reg_addr=2) reads 1 whenever the receive FIFO holds at least one word.
- R4: A read strobe at reg_addr=0 returns the oldest received word and removes it. When the receive FIFO is empty, reg_rdata at reg_addr=0 is 0 and the read has no effect.
- R5: Receive-complete (bit 3 of the interrupt status at reg_addr=4) is set in the cycle after an accepted receive word makes the fill equal to the receive threshold. A threshold of 0 never sets it.
- R6: Receive-overrun (bit 0 of the interrupt status) is set when rx_push arrives while the receive FIFO holds 8 words. That word is discarded.
- R7: Interrupt status bit 9 reads receive-FIFO-not-empty. Bit 4 (transmit-complete) is set when the engine takes the last word of the transmit FIFO. A flush does not set bit 4.
- R8: Writing reg_addr=4 clears status bit 4, 3 or 0 wherever the written data has a 1. Bits written as 0 are unchanged. A flag event in the same cycle as its clear leaves the flag set.
- R9: The interrupt enable register is at reg_addr=3, with receive-complete enable at bit 3 and receive-overrun enable at bit 0. irq is the OR of each of these flags ANDed with its enable. Flags stay set while their enable is 0.
- R10: After reset both FIFOs are empty, all registers read 0, and irq and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| tx_word | output | 32 | Oldest transmit word |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| tx_take | input | 1 | Engine takes tx_word |
| rx_word | input | 32 | Word from the engine |
| rx_push | input | 1 | rx_word is valid this cycle |

## Verification
The bench fills the receive FIFO one word past its depth. A design that stored the ninth word, or failed to flag overrun, shows up in the read-back order and in status bit 0. It checks that receive-complete fires exactly at the threshold fill and never with a zero threshold; an off-by-one comparison would flag one word early or late. It also drives a clear and a receive-complete event in the same cycle, where clear-wins logic would lose the event. Finally it checks that flags remain set while masked, which a design that gated the flag instead of the output would fail.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
    localparam int FIFO_DEPTH = 8;
    localparam int WORD_W     = 32;
    localparam int THR_W      = 4;

    typedef enum logic [2:0] {
        ADR_DATA = 3'd0,
        ADR_FCTL = 3'd1,
        ADR_STAT = 3'd2,
        ADR_IEN  = 3'd3,
        ADR_ISR  = 3'd4
    } reg_adr_e;

    localparam int BIT_TX_FLUSH = 12;
    localparam int BIT_TX_THR   = 8;
    localparam int BIT_RX_FLUSH = 4;
    localparam int BIT_RX_THR   = 0;
    localparam int BIT_RDY      = 9;
    localparam int BIT_TC       = 4;
    localparam int BIT_RC       = 3;
    localparam int BIT_ROR      = 0;
endpackage

// File: rtl/spi_fifo_irq_buf.sv
module spi_fifo_irq_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign count   = cnt;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (!push_ok && pop_ok) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end
endmodule

// File: rtl/spi_fifo_irq_flags.sv
module spi_fifo_irq_flags #(
    parameter int CW    = 4,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic             rx_push_ok,
    input  logic             rx_pop_ok,
    input  logic             rx_full,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             tx_push_ok,
    input  logic             tx_pop_ok,
    input  logic [CW-1:0]    tx_cnt,
    input  logic             clr_wr,
    input  logic             clr_tc,
    input  logic             clr_rc,
    input  logic             clr_ror,
    input  logic             ien_wr,
    input  logic             ien_rc_d,
    input  logic             ien_ror_d,
    output logic             sts_tc,
    output logic             sts_rc,
    output logic             sts_ror,
    output logic             ien_rc,
    output logic             ien_ror,
    output logic             irq
);
    logic hit_rc, hit_ror, hit_tc;

    assign hit_rc  = rx_push_ok && !rx_pop_ok && (rx_thr != '0)
                     && ((32'(rx_cnt) + 32'd1) == 32'(rx_thr));
    assign hit_ror = rx_push && rx_full;
    assign hit_tc  = tx_pop_ok && !tx_push_ok && (tx_cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_tc  <= 1'b0;
            sts_rc  <= 1'b0;
            sts_ror <= 1'b0;
            ien_rc  <= 1'b0;
            ien_ror <= 1'b0;
        end else begin
            sts_tc  <= hit_tc  || (sts_tc  && !(clr_wr && clr_tc));
            sts_rc  <= hit_rc  || (sts_rc  && !(clr_wr && clr_rc));
            sts_ror <= hit_ror || (sts_ror && !(clr_wr && clr_ror));
            if (ien_wr) begin
                ien_rc  <= ien_rc_d;
                ien_ror <= ien_ror_d;
            end
        end
    end

    assign irq = (sts_rc && ien_rc) || (sts_ror && ien_ror);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic [DW-1:0] tx_word,
    output logic          tx_valid,
    input  logic          tx_take,
    input  logic [DW-1:0] rx_word,
    input  logic          rx_push
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [THR_W-1:0] tx_thr, rx_thr;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic [DW-1:0]    rx_dout;
    logic tx_full, tx_empty, tx_push_ok, tx_pop_ok;
    logic rx_full, rx_empty, rx_push_ok, rx_pop_ok;
    logic sts_tc, sts_rc, sts_ror, ien_rc, ien_ror;
    logic wr_data, wr_fctl, wr_ien, wr_isr, rd_data;
    logic unused_wbits;

    assign wr_data = reg_wr && (reg_addr == ADR_DATA);
    assign wr_fctl = reg_wr && (reg_addr == ADR_FCTL);
    assign wr_ien  = reg_wr && (reg_addr == ADR_IEN);
    assign wr_isr  = reg_wr && (reg_addr == ADR_ISR);
    assign rd_data = reg_rd && (reg_addr == ADR_DATA);
    assign unused_wbits = ^{reg_wdata[31:13], reg_wdata[7:5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (wr_fctl) begin
            tx_thr <= reg_wdata[BIT_TX_THR +: THR_W];
            rx_thr <= reg_wdata[BIT_RX_THR +: THR_W];
        end
    end

    spi_fifo_irq_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_fctl && reg_wdata[BIT_TX_FLUSH]),
        .push(wr_data), .din(reg_wdata[DW-1:0]),
        .pop(tx_take), .dout(tx_word), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    spi_fifo_irq_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_fctl && reg_wdata[BIT_RX_FLUSH]),
        .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_dout), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    spi_fifo_irq_flags #(.CW(CW), .THR_W(THR_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
        .rx_full(rx_full), .rx_cnt(rx_cnt), .rx_thr(rx_thr),
        .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok), .tx_cnt(tx_cnt),
        .clr_wr(wr_isr), .clr_tc(reg_wdata[BIT_TC]),
        .clr_rc(reg_wdata[BIT_RC]), .clr_ror(reg_wdata[BIT_ROR]),
        .ien_wr(wr_ien), .ien_rc_d(reg_wdata[BIT_RC]),
        .ien_ror_d(reg_wdata[BIT_ROR]),
        .sts_tc(sts_tc), .sts_rc(sts_rc), .sts_ror(sts_ror),
        .ien_rc(ien_rc), .ien_ror(ien_ror), .irq(irq)
    );

    assign tx_valid = !tx_empty;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_DATA: if (!rx_empty) reg_rdata[DW-1:0] = rx_dout;
            ADR_FCTL: begin
                reg_rdata[BIT_TX_THR +: THR_W] = tx_thr;
                reg_rdata[BIT_RX_THR +: THR_W] = rx_thr;
            end
            ADR_STAT: reg_rdata[0] = !rx_empty;
            ADR_IEN: begin
                reg_rdata[BIT_RC]  = ien_rc;
                reg_rdata[BIT_ROR] = ien_ror;
            end
            ADR_ISR: begin
                reg_rdata[BIT_RDY] = !rx_empty;
                reg_rdata[BIT_TC]  = sts_tc;
                reg_rdata[BIT_RC]  = sts_rc;
                reg_rdata[BIT_ROR] = sts_ror;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic          rx_push,
    input logic          irq,
    input logic [CW-1:0] rx_cnt,
    input logic          ien_rc,
    input logic          ien_ror,
    input logic          sts_ror
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && reg_wdata[4]) |=> (rx_cnt == '0));

    p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0 && rx_cnt == '0) |-> (reg_rdata == 32'd0));

    p_full_push_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == CW'(DEPTH)) |=> sts_ror);

    p_ror_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ror && !(reg_wr && reg_addr == 3'd4 && reg_wdata[0])) |=> sts_ror);

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_rc && !ien_ror) |-> !irq);
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push),
    .irq(irq), .rx_cnt(rx_cnt), .ien_rc(ien_rc), .ien_ror(ien_ror),
    .sts_ror(sts_ror)
);

// File: tb/test_spi_fifo_irq.sv
`timescale 1ns/1ps
module test_spi_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_push = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit take_en = 0;
    int n_taken = 0;
    logic [31:0] tx_exp[$];
    logic [31:0] rx_exp[$];
    logic [31:0] v;

    always #2 clk = ~clk;

    spi_fifo_irq i_spi_fifo_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .tx_word(tx_word), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_word(rx_word), .rx_push(rx_push)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-UNIT FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd0 && tx_exp.size() < 8) tx_exp.push_back(d);
        if (a == 3'd1 && d[12]) tx_exp.delete();
        if (a == 3'd1 && d[4]) rx_exp.delete();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #0.5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_in(input logic [31:0] w);
        @(negedge clk);
        rx_push = 1'b1; rx_word = w;
        if (rx_exp.size() < 8) rx_exp.push_back(w);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Scoreboard read of receive data (R4)
    task automatic rd_rx_expect();
        logic [31:0] d;
        rd(3'd0, d);
        if (rx_exp.size() > 0) check("R4 rx order", d, rx_exp.pop_front());
        else check("R4 empty read", d, 32'd0);
    endtask

    // Engine-side monitor: takes TX words and compares against the queue (R1)
    initial begin
        forever begin
            @(negedge clk);
            if (take_en && tx_valid) begin
                if (tx_exp.size() > 0) check("R1 tx order", tx_word, tx_exp.pop_front());
                else check("R1 tx extra word", tx_word, 32'hxxxx_xxxx);
                n_taken++;
                tx_take = 1'b1;
            end else begin
                tx_take = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FIFO-UNIT FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        #0.5 check("R10 irq", {31'd0, irq}, 32'd0);
        check("R10 tx_valid", {31'd0, tx_valid}, 32'd0);
        rd(3'd2, v); check("R10 status", v, 32'd0);
        rd(3'd4, v); check("R10 isr", v, 32'd0);
        rd(3'd1, v); check("R10 fctl", v, 32'd0);

        // R2 thresholds read back, flush bits read 0
        wr(3'd1, 32'h0000_0503);
        rd(3'd1, v); check("R2 thr readback", v, 32'h0000_0503);
        wr(3'd3, 32'h9);
        rd(3'd3, v); check("R9 enable readback", v, 32'h9);

        // R5 threshold reached on third word
        rx_in(32'hA000_0001);
        rx_in(32'hA000_0002);
        rd(3'd4, v); check("R5 below thr", v & 32'h8, 32'h0);
        check("R7 ready bit", v & 32'h200, 32'h200);
        rd(3'd2, v); check("R3 not empty", v, 32'h1);
        rx_in(32'hA000_0003);
        rd(3'd4, v); check("R5 at thr", v & 32'h8, 32'h8);
        #0.5 check("R9 irq on rc", {31'd0, irq}, 32'd1);

        for (int i = 0; i < 3; i++) rd_rx_expect();
        rd(3'd2, v); check("R3 empty", v, 32'h0);
        rd_rx_expect();

        // R8 clear receive-complete
        wr(3'd4, 32'h8);
        rd(3'd4, v); check("R8 rc cleared", v, 32'h0);
        #0.5 check("R8 irq low", {31'd0, irq}, 32'd0);

        // R6 overrun with enables off, R9 sticky flags
        wr(3'd3, 32'h0);
        for (int i = 0; i < 9; i++) rx_in(32'hB000_0000 + 32'(i));
        rd(3'd4, v); check("R6 overrun flag", v & 32'h1, 32'h1);
        #0.5 check("R9 masked irq", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h0);
        rd(3'd4, v); check("R8 zero write no effect", v & 32'h9, 32'h9);
        wr(3'd3, 32'h1);
        #0.5 check("R9 irq on enabled ror", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 8; i++) rd_rx_expect();
        rd_rx_expect();
        wr(3'd4, 32'h9);
        rd(3'd4, v); check("R8 both cleared", v, 32'h0);

        // R5 zero threshold never sets
        wr(3'd1, 32'h0);
        for (int i = 0; i < 8; i++) rx_in(32'hC000_0000 + 32'(i));
        rd(3'd4, v); check("R5 zero thr", v & 32'h8, 32'h0);
        // R2 receive flush
        wr(3'd1, 32'h0000_0010);
        rd(3'd2, v); check("R2 rx flush", v, 32'h0);
        rd(3'd1, v); check("R2 flush bit reads 0", v, 32'h0);
        rd_rx_expect();

        // R1 transmit FIFO depth and order, R7 transmit-complete
        for (int i = 0; i < 9; i++) wr(3'd0, 32'hD000_0000 + 32'(i));
        rd(3'd4, v); check("R7 tc not yet", v & 32'h10, 32'h0);
        n_taken = 0;
        take_en = 1;
        repeat (14) @(negedge clk);
        take_en = 0;
        @(negedge clk);
        check("R1 words taken", 32'(n_taken), 32'd8);
        #0.5 check("R1 tx drained", {31'd0, tx_valid}, 32'd0);
        rd(3'd4, v); check("R7 tc set", v & 32'h10, 32'h10);
        wr(3'd4, 32'h10);
        rd(3'd4, v); check("R8 tc cleared", v & 32'h10, 32'h0);

        // R2 transmit flush, does not set transmit-complete
        wr(3'd0, 32'hE1); wr(3'd0, 32'hE2);
        #0.5 check("R1 tx valid", {31'd0, tx_valid}, 32'd1);
        check("R1 tx head", tx_word, 32'hE1);
        wr(3'd1, 32'h0000_1000);
        #0.5 check("R2 tx flush", {31'd0, tx_valid}, 32'd0);
        rd(3'd4, v); check("R7 flush no tc", v & 32'h10, 32'h0);

        // R8 set wins over clear in the same cycle
        wr(3'd1, 32'h0000_0011);
        @(negedge clk);
        rx_push = 1'b1; rx_word = 32'hF00D;
        rx_exp.push_back(32'hF00D);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h8;
        @(negedge clk);
        rx_push = 1'b0; reg_wr = 1'b0;
        rd(3'd4, v); check("R8 set beats clear", v & 32'h8, 32'h8);
        rd_rx_expect();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule